// File: doc/BRIEF.md
# Sequenced ADC Acquisition Controller

This block runs the acquisition cycle of an external parallel ADC of up to 16 bits. One mode input picks what begins a conversion: a single request pulse, or a periodic timer tick. A second mode input picks what marks the end of a conversion: the converter's own ready pin, or an internal trigger pulse such as a timer event. When a conversion ends, the block strobes the converter's read line, latches the sample and offers it to a link transmitter as two bytes.

An 8-bit channel address drives an analog multiplexer ahead of the converter. Software loads a start channel, and the address steps by one after every captured sample, so a run of conversions walks through the multiplexer inputs.

A start that arrives while a conversion is still in progress is dropped. A sticky flag records that this happened.

Top module: `adc_sequencer`

## Requirements
- R1: After reset, adcStart, adcRead and txValid are low, overrun is low and chanAddr is 0x00.
- R2: With startMode = 0, a convReq pulse while idle makes adcStart high for exactly one clock, in the cycle after the request. timerTick has no effect in this mode.
- R3: With startMode = 1, a timerTick pulse while idle starts a conversion in the same way. convReq has no effect in this mode.
- R4: With doneMode = 0, completion is adcReady sampled high while the block waits for the conversion. doneTrig has no effect in this mode.
- R5: With doneMode = 1, completion is a doneTrig pulse while the block waits. adcReady has no effect in this mode.
- R6: adcRead goes high in the cycle after completion is sensed and stays high for exactly two clocks. adcData is latched at the clock edge that ends the second of those clocks.
- R7: The sample is zero-extended to 16 bits and sent as two bytes, most significant byte first. Each byte is presented on txData with txValid high. A byte is held stable until a cycle in which txReady is high, and the block returns to idle after the low byte is accepted.
- R8: A start event of the selected source that arrives while the block is not idle is ignored: no adcStart is produced. It sets overrun, which stays high until reset.
- R9: A loadAddr pulse copies startAddr into chanAddr. chanAddr increments by one at each sample capture and wraps from 0xFF to 0x00. When a load and a capture fall in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startMode | input | 1 | 0: request starts, 1: timer tick starts |
| doneMode | input | 1 | 0: ready pin completes, 1: internal trigger completes |
| convReq | input | 1 | Single conversion request pulse |
| timerTick | input | 1 | Periodic start pulse |
| doneTrig | input | 1 | Internal completion pulse |
| adcReady | input | 1 | Converter ready level |
| adcData | input | DATA_W | Converter parallel data |
| adcStart | output | 1 | One-clock start-convert pulse |
| adcRead | output | 1 | Read strobe, two clocks |
| loadAddr | input | 1 | Load start channel into the address generator |
| startAddr | input | ADDR_W | Programmed start channel |
| chanAddr | output | ADDR_W | Multiplexer channel select |
| txData | output | 8 | Byte to the link transmitter |
| txValid | output | 1 | txData is valid |
| txReady | input | 1 | Transmitter accepts the byte |
| overrun | output | 1 | Sticky start-while-busy flag |

## Verification
Two pairs of events can land in the same cycle. An address load can coincide with the increment that a capture causes. The bench provokes this by raising loadAddr during the second read clock and expects chanAddr to show the loaded value, not that value plus one, and not the old address plus one. A selected start can also coincide with a conversion in progress. The bench fires one while the block waits for completion and judges it by the absence of adcStart, the overrun flag rising and staying high, and the interrupted conversion still delivering its two bytes unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SAMPLE_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_WAIT, ST_READ1, ST_READ2, ST_SEND_HI, ST_SEND_LO
  } seqState_t;

  typedef struct packed {
    logic capture;   // latch converter data
    logic advance;   // step channel address
    logic sendHi;    // present upper byte
  } dpCtl_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startMode,
  input  logic   doneMode,
  input  logic   convReq,
  input  logic   timerTick,
  input  logic   doneTrig,
  input  logic   adcReady,
  input  logic   txReady,
  output logic   adcStart,
  output logic   adcRead,
  output logic   txValid,
  output logic   overrun,
  output dpCtl_t ctl
);
  seqState_t state, stateNext;
  logic startEvt, doneEvt, overrunQ;

  assign startEvt = startMode ? timerTick : convReq;
  assign doneEvt  = doneMode  ? doneTrig  : adcReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (startEvt) stateNext = ST_START;
      ST_START:   stateNext = ST_WAIT;
      ST_WAIT:    if (doneEvt) stateNext = ST_READ1;
      ST_READ1:   stateNext = ST_READ2;
      ST_READ2:   stateNext = ST_SEND_HI;
      ST_SEND_HI: if (txReady) stateNext = ST_SEND_LO;
      ST_SEND_LO: if (txReady) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      overrunQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (startEvt && state != ST_IDLE) overrunQ <= 1'b1;
    end
  end

  assign adcStart    = (state == ST_START);
  assign adcRead     = (state == ST_READ1) || (state == ST_READ2);
  assign txValid     = (state == ST_SEND_HI) || (state == ST_SEND_LO);
  assign overrun     = overrunQ;
  assign ctl.capture = (state == ST_READ2);
  assign ctl.advance = (state == ST_READ2);
  assign ctl.sendHi  = (state == ST_SEND_HI);

  a_r2_start_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);
  a_r6_read_two_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcRead) |=> adcRead);
  a_r6_read_two_end: assert property (@(posedge clk) disable iff (!rstN)
    (adcRead && $past(adcRead)) |=> !adcRead);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startEvt && !adcStart && !adcRead && !txValid && state == ST_WAIT) |=> !adcStart);
  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] adcData,
  input  logic              loadAddr,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [7:0]        txData
);
  localparam int PAD_W = SAMPLE_W - DATA_W;

  logic [SAMPLE_W-1:0] sampleExt, sampleQ;
  logic [ADDR_W-1:0]   addrQ;

  generate
    if (PAD_W > 0) begin : gPad
      assign sampleExt = {{PAD_W{1'b0}}, adcData};
    end else begin : gFull
      assign sampleExt = adcData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleQ <= '0;
      addrQ   <= '0;
    end else begin
      if (ctl.capture) sampleQ <= sampleExt;
      if (loadAddr)         addrQ <= startAddr;
      else if (ctl.advance) addrQ <= addrQ + 1'b1;
    end
  end

  assign chanAddr = addrQ;
  assign txData   = ctl.sendHi ? sampleQ[15:8] : sampleQ[7:0];

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !loadAddr && addrQ == '1) |=> addrQ == '0);
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    loadAddr |=> addrQ == $past(startAddr));
  a_r7_byte_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sendHi && !ctl.capture) |=> $stable(sampleQ));
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startMode,
  input  logic              doneMode,
  input  logic              convReq,
  input  logic              timerTick,
  input  logic              doneTrig,
  input  logic              adcReady,
  input  logic [DATA_W-1:0] adcData,
  output logic              adcStart,
  output logic              adcRead,
  input  logic              loadAddr,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              overrun
);
  dpCtl_t ctl;

  adc_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startMode(startMode), .doneMode(doneMode),
    .convReq(convReq), .timerTick(timerTick), .doneTrig(doneTrig),
    .adcReady(adcReady), .txReady(txReady), .adcStart(adcStart),
    .adcRead(adcRead), .txValid(txValid), .overrun(overrun), .ctl(ctl)
  );

  adc_seq_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .adcData(adcData),
    .loadAddr(loadAddr), .startAddr(startAddr), .chanAddr(chanAddr),
    .txData(txData)
  );

  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
endmodule

// File: tb/tb_adc_sequencer.sv
module tb_adc_sequencer;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic startMode = 0, doneMode = 0, convReq = 0, timerTick = 0, doneTrig = 0;
  logic adcReady = 0, loadAddr = 0, txReady = 0;
  logic [15:0] adcData = '0;
  logic [7:0]  startAddr = '0;
  logic adcStart, adcRead, txValid, overrun;
  logic [7:0] chanAddr, txData;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_sequencer dut (
    .clk(clk), .rstN(rstN), .startMode(startMode), .doneMode(doneMode),
    .convReq(convReq), .timerTick(timerTick), .doneTrig(doneTrig),
    .adcReady(adcReady), .adcData(adcData), .adcStart(adcStart),
    .adcRead(adcRead), .loadAddr(loadAddr), .startAddr(startAddr),
    .chanAddr(chanAddr), .txData(txData), .txValid(txValid),
    .txReady(txReady), .overrun(overrun)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic loadStart(input logic [7:0] a);
    startAddr = a; loadAddr = 1; step(); loadAddr = 0;
    chk("R9 load", chanAddr, a);
  endtask

  // Block is waiting; drive completion, expect read, capture and send.
  task automatic readAndSend(input bit viaTrig, input logic [7:0] hi, input logic [7:0] lo,
                             input logic [7:0] expAddr, input bit collide, input logic [7:0] newAddr);
    if (viaTrig) doneTrig = 1; else adcReady = 1;
    step(); doneTrig = 0; adcReady = 0;
    chk("R6 read first clock", adcRead, 1);
    if (collide) begin startAddr = newAddr; loadAddr = 1; end
    step();
    chk("R6 read second clock", adcRead, 1);
    step(); loadAddr = 0;
    chk("R6 read ends", adcRead, 0);
    chk("R7 high byte valid", txValid, 1);
    chk("R7 high byte", txData, hi);
    chk("R9 channel after capture", chanAddr, expAddr);
    step();
    chk("R7 held valid", txValid, 1);
    chk("R7 held byte", txData, hi);
    txReady = 1; step();
    chk("R7 low byte valid", txValid, 1);
    chk("R7 low byte", txData, lo);
    step(); txReady = 0;
    chk("R7 back to idle", txValid, 0);
  endtask

  task automatic testReset();
    chk("R1 adcStart", adcStart, 0);
    chk("R1 adcRead", adcRead, 0);
    chk("R1 txValid", txValid, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 chanAddr", chanAddr, 0);
  endtask

  task automatic testRequestPin();
    startMode = 0; doneMode = 0;
    loadStart(8'h10);
    timerTick = 1; step(); timerTick = 0;
    chk("R2 tick ignored", adcStart, 0);
    step();
    chk("R2 tick ignored later", adcStart, 0);
    convReq = 1; step(); convReq = 0;
    chk("R2 start pulse", adcStart, 1);
    step();
    chk("R2 pulse one clock", adcStart, 0);
    doneTrig = 1; step(); doneTrig = 0;
    chk("R4 trigger ignored", adcRead, 0);
    adcData = 16'hA55A;
    readAndSend(0, 8'hA5, 8'h5A, 8'h11, 0, 8'h00);
    chk("R8 no overrun yet", overrun, 0);
  endtask

  task automatic testTimerTrig();
    startMode = 1; doneMode = 1;
    convReq = 1; step(); convReq = 0;
    chk("R3 request ignored", adcStart, 0);
    timerTick = 1; step(); timerTick = 0;
    chk("R3 tick starts", adcStart, 1);
    step();
    adcReady = 1; step(); adcReady = 0;
    chk("R5 ready pin ignored", adcRead, 0);
    timerTick = 1; step(); timerTick = 0;
    chk("R8 busy start no pulse", adcStart, 0);
    chk("R8 overrun set", overrun, 1);
    adcData = 16'h1234;
    readAndSend(1, 8'h12, 8'h34, 8'h12, 0, 8'h00);
  endtask

  task automatic testWrapCollide();
    startMode = 0; doneMode = 0;
    loadStart(8'hFF);
    convReq = 1; step(); convReq = 0; step();
    adcData = 16'h00C3;
    readAndSend(0, 8'h00, 8'hC3, 8'h00, 0, 8'h00);
    convReq = 1; step(); convReq = 0; step();
    adcData = 16'hFFFF;
    readAndSend(0, 8'hFF, 8'hFF, 8'h40, 1, 8'h40);
    chk("R8 overrun sticky", overrun, 1);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testRequestPin();
    testTimerTrig();
    testWrapCollide();
    finishRun();
  end
endmodule